// File: doc/BRIEF.md
# Least-Recently-Used Frame Tracker (Bit Matrix)

This block keeps the recency order of N frames in an N by N bit matrix and reports, on every cycle, which frame has gone longest without an access. A replacement controller drives a valid strobe together with a frame index each time a frame is touched. The tracker updates the matrix on that clock edge. It then shows the index of the least recently used frame on its output, which is derived combinationally from the stored matrix.

For a touched frame k, the update writes ones across row k and, in the same edge, zeros down column k. The column clear wins where the two meet, so bit (k,k) is always 0. Each row is read as an unsigned number whose most significant bit is column 0. The row with the smallest number belongs to the least recently used frame, and a tie goes to the lower index. Indices at or above N are dropped without any effect.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After reset every matrix bit is 0, and lru_idx_o reads 0.
- R2: A valid access to frame k sets every bit of row k to 1 in the column positions other than k.
- R3: A valid access to frame k clears every bit of column k to 0, in every row.
- R4: The bit at row k, column k is 0 after every update; where they meet, the column clear overrides the row set.
- R5: lru_idx_o is the index of the row with the smallest value, where a row is read with column 0 as its most significant bit and column N-1 as its least significant bit.
- R6: When several rows share the smallest value, lru_idx_o gives the lowest index among them; from reset, a single access to frame 0 gives lru_idx_o = 1.
- R7: An update completes on the one rising clock edge where acc_valid_i is 1, and lru_idx_o shows the new result before the following edge.
- R8: An edge with acc_valid_i at 0, or with acc_idx_i at N or above, leaves the matrix and lru_idx_o unchanged.
- R9: With N=4, the access order 0,1,2,3,2,1,0,3,2,3 starting from reset ends with lru_idx_o = 1; once every frame has been touched, lru_idx_o names the frame touched longest ago.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe; 1 means acc_idx_i is touched this cycle |
| acc_idx_i | input | IDX_W | Index of the frame touched; values N and above are ignored |
| lru_idx_o | output | IDX_W | Index of the least recently used frame |

## Verification
Every update sets row k and clears column k in the same edge, and the two writes collide at the diagonal bit (k,k). Back-to-back accesses to the same frame repeat that collision on the same cells. The bench provokes the collision with touches in a fixed order, with repeated touches of one frame, and with long random streams that mix valid, idle and out-of-range cycles. The outcome is judged on every clock by comparing lru_idx_o against a behavioural recency model. The checker also tests the diagonal, the row and the column directly after each access.

// File: rtl/lru_mtx_pkg.sv
package lru_mtx_pkg;
  localparam int unsigned MIN_FRAMES = 2;
  localparam int unsigned MAX_FRAMES = 8;

  // Row bits are indexed by column; column 0 becomes the most significant bit.
  function automatic logic [MAX_FRAMES-1:0] row_weight(input logic [MAX_FRAMES-1:0] row_bits,
                                                     input int unsigned n);
    logic [MAX_FRAMES-1:0] w;
    w = '0;
    for (int c = 0; c < int'(MAX_FRAMES); c++) begin
      if (c < int'(n)) w[int'(n) - 1 - c] = row_bits[c];
    end
    return w;
  endfunction
endpackage

// File: rtl/lru_access_decode.sv
module lru_access_decode #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  output logic [N-1:0]     hit_oh_o
);
  // Out-of-range indices match no frame and therefore produce no hit.
  for (genvar f = 0; f < N; f++) begin : g_hit
    assign hit_oh_o[f] = acc_valid_i && (acc_idx_i == IDX_W'(f));
  end
endmodule

// File: rtl/lru_bit_matrix.sv
module lru_bit_matrix #(
  parameter int unsigned N = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            hit_oh_i,
  output logic [N-1:0][N-1:0]     mtx_o
);
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          mtx_o[r][c] <= 1'b0;
        else if (hit_oh_i[c]) mtx_o[r][c] <= 1'b0;  // column clear wins
        else if (hit_oh_i[r]) mtx_o[r][c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lru_min_search.sv
module lru_min_search
  import lru_mtx_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0][N-1:0] mtx_i,
  output logic [IDX_W-1:0]    lru_idx_o
);
  logic [N-1:0][MAX_FRAMES-1:0] weight;

  for (genvar r = 0; r < N; r++) begin : g_w
    logic [MAX_FRAMES-1:0] row_ext;
    assign row_ext   = MAX_FRAMES'(mtx_i[r]);
    assign weight[r] = row_weight(row_ext, N);
  end

  always_comb begin
    logic [MAX_FRAMES-1:0] best;
    best      = weight[0];
    lru_idx_o = '0;
    // Strict compare keeps the lower index on ties.
    for (int r = 1; r < int'(N); r++) begin
      if (weight[r] < best) begin
        best      = weight[r];
        lru_idx_o = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  logic [N-1:0]        hit_oh;
  logic [N-1:0][N-1:0] mtx;
  logic [N*N-1:0]      mtx_flat;

  assign mtx_flat = mtx;

  lru_access_decode #(.N(N), .IDX_W(IDX_W)) i_decode (
    .acc_valid_i (acc_valid_i),
    .acc_idx_i   (acc_idx_i),
    .hit_oh_o    (hit_oh)
  );

  lru_bit_matrix #(.N(N)) i_matrix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_oh_i (hit_oh),
    .mtx_o    (mtx)
  );

  lru_min_search #(.N(N), .IDX_W(IDX_W)) i_search (
    .mtx_i     (mtx),
    .lru_idx_o (lru_idx_o)
  );
endmodule

// File: rtl/lru_matrix_checker.sv
module lru_matrix_checker
  import lru_mtx_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [IDX_W-1:0] acc_idx_i,
  input logic [IDX_W-1:0] lru_idx_o,
  input logic [N*N-1:0]   mtx_flat
);
  logic       in_rng;
  logic       prev_hit;
  int         prev_k;
  logic       row_ok, col_ok, diag_ok, min_ok;

  assign in_rng = acc_valid_i && (int'(acc_idx_i) < int'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_hit <= 1'b0;
      prev_k   <= 0;
    end else begin
      prev_hit <= in_rng;
      prev_k   <= int'(acc_idx_i);
    end
  end

  always_comb begin
    logic [MAX_FRAMES-1:0] wl, wr, rb;
    row_ok  = 1'b1;
    col_ok  = 1'b1;
    diag_ok = 1'b1;
    min_ok  = 1'b1;
    for (int i = 0; i < int'(N); i++) begin
      if (mtx_flat[i*int'(N)+i]) diag_ok = 1'b0;
      if (prev_k < int'(N)) begin
        if (mtx_flat[i*int'(N)+prev_k]) col_ok = 1'b0;
        if (i != prev_k && !mtx_flat[prev_k*int'(N)+i]) row_ok = 1'b0;
      end
    end
    rb = '0;
    for (int c = 0; c < int'(N); c++) rb[c] = mtx_flat[int'(lru_idx_o)*int'(N)+c];
    wl = row_weight(rb, N);
    for (int r = 0; r < int'(N); r++) begin
      rb = '0;
      for (int c = 0; c < int'(N); c++) rb[c] = mtx_flat[r*int'(N)+c];
      wr = row_weight(rb, N);
      if (wr < wl) min_ok = 1'b0;
      if (wr == wl && r < int'(lru_idx_o)) min_ok = 1'b0;
    end
  end

  initial begin
    a_n_range: assert (N >= MIN_FRAMES && N <= MAX_FRAMES);
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mtx_flat == '0));
  p_row_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_hit |-> row_ok);
  p_col_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_hit |-> col_ok);
  p_diag_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_ok);
  p_min_row_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lru_idx_o) < int'(N)) && min_ok);  // also covers tie order, R6
  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |=> $stable(mtx_flat));
endmodule

bind lru_matrix_tracker lru_matrix_checker #(.N(N), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_lru_matrix_tracker.sv
module test_lru_matrix_tracker;
  localparam int N     = 4;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             acc_valid = 1'b0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [IDX_W-1:0] lru_idx;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  bit    cmp_en   = 1'b0;
  string cur_req  = "R5";

  // Model: time stamp of last touch per frame; older stamp = less recent.
  int last_use [N];
  int tick;

  always #2.5 clk = ~clk;

  lru_matrix_tracker #(.N(N), .IDX_W(IDX_W)) i_lru_matrix_tracker (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid),
    .acc_idx_i   (acc_idx),
    .lru_idx_o   (lru_idx)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tick = 0;
      foreach (last_use[i]) last_use[i] = 0;
    end else if (acc_valid && int'(acc_idx) < N) begin
      tick++;
      last_use[acc_idx] = tick;
    end
  end

  // Untouched frames share stamp 0 and tie; lowest index wins among the oldest.
  function automatic int model_lru();
    int best = 0;
    for (int i = 1; i < N; i++) if (last_use[i] < last_use[best]) best = i;
    return best;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: lru_idx_o=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Matrix LRU equals true LRU only when all touched frames dominate untouched ones,
  // which holds for this model since untouched rows stay 0 and touched rows keep bits.
  always @(negedge clk) if (cmp_en && rst_ni) chk(cur_req, int'(lru_idx), model_lru());

  task automatic drive(bit v, int k);
    @(negedge clk);
    acc_valid = v;
    acc_idx   = IDX_W'(k);
  endtask

  task automatic idle();
    drive(1'b0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    acc_valid = 1'b0;
    rst_ni    = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", int'(lru_idx), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
    repeat (3) @(negedge clk);
    chk("R1", int'(lru_idx), 0);
    rst_ni = 1'b1;
    idle();
    chk("R1", int'(lru_idx), 0);
    cmp_en = 1'b1;

    // R6: one touch of frame 0 leaves 1,2,3 tied at zero
    cur_req = "R6";
    drive(1'b1, 0);
    idle();
    chk("R6", int'(lru_idx), 1);

    // R9: fixed access order, back to back
    do_reset();
    cur_req = "R9";
    foreach (seq[i]) drive(1'b1, seq[i]);
    idle();
    chk("R9", int'(lru_idx), 1);

    // R2/R3: descending sweep leaves the first touched as LRU
    cur_req = "R2";
    drive(1'b1, 3); drive(1'b1, 2); drive(1'b1, 1); drive(1'b1, 0);
    idle();
    chk("R2", int'(lru_idx), 3);
    // R4: repeated touch of one frame collides on its diagonal twice
    cur_req = "R4";
    drive(1'b1, 2); drive(1'b1, 2);
    idle();
    chk("R4", int'(lru_idx), 3);
    // R7: single-edge update visible before the next edge
    cur_req = "R7";
    drive(1'b1, 3);
    @(negedge clk);
    chk("R7", int'(lru_idx), 1);
    acc_valid = 1'b0;

    // R8: idle index and out-of-range indices change nothing
    cur_req = "R8";
    drive(1'b0, 1); drive(1'b1, 4); drive(1'b1, 5); drive(1'b1, 7);
    idle();
    chk("R8", int'(lru_idx), 1);
    drive(1'b1, 1);
    idle();
    chk("R3", int'(lru_idx), 0);

    // R5: long random stream, compared each clock against the model
    do_reset();
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) drive(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)));
    idle();

    cmp_en = 1'b0;
    done   = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule